// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is a purely combinational integer arithmetic unit with its own small operation decoder. A main controller supplies a 2-bit operation class, and the instruction supplies a 6-bit function field. The decoder turns that pair into a 3-bit operation code. The datapath applies that code to two operands and returns a result, a zero flag and a signed-overflow flag. The operation class takes priority over the function field. Memory-address computation always adds. Equality branches always subtract, so the zero flag can decide the branch. Register-register instructions are decoded from the function field.

The top bit of the operation code doubles as the subtract enable. When it is set, the second operand is inverted and the carry-in is forced high. One carry-skip adder therefore serves add, subtract and set-on-less-than. The operand width and the carry-skip group size are parameters. The default width is 32 bits, with groups of 4.

Top module: `alu2_top`

## Requirements
- R1: With operation class 00 the decoded code is 010 (add), whatever the function field holds.
- R2: With operation class 01 the decoded code is 110 (subtract), whatever the function field holds.
- R3: With class 10 only function bits [3:0] matter. The patterns 0000, 0010, 0100, 0101 and 1010 give the codes 010, 110, 000, 001 and 111, and bits [5:4] have no effect.
- R4: Class 11 decodes the function field exactly as class 10 does.
- R5: Under class 10 or 11, any other value of function bits [3:0] gives 010 (add).
- R6: Code 010 yields a+b and code 110 yields a-b, both modulo 2^WIDTH. Bit 2 of the code selects inversion of b with a carry-in of 1.
- R7: Code 000 yields the bitwise AND of a and b, and code 001 yields the bitwise OR.
- R8: Code 111 yields 1 in bit 0 when a < b as signed numbers, and 0 otherwise. All other bits are 0. The comparison stays correct when a-b overflows.
- R9: The zero flag is 1 exactly when every result bit is 0.
- R10: The overflow flag is 1 only under code 010 or 110, and only when the exact signed sum or difference falls outside the WIDTH-bit signed range. It is 0 for AND, OR and set-on-less-than.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| alu_op | output | 3 | Decoded operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when the result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds two copies of the block against one behavioural model. The first uses the default 32-bit width with 4-bit skip groups. The second uses an 8-bit width with 2-bit groups. The 8-bit copy makes it possible to sweep every value of the first operand against a spread of second operands under every operation. That sweep reaches each carry-skip bypass, every overflow corner and every sign combination for the comparison. The 32-bit copy covers every class against every function code, and also the extreme signed values where add, subtract and set-on-less-than overflow.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

  localparam int CLASS_W = 2;
  localparam int FUNCT_W = 6;
  localparam int KEY_W   = 4;
  localparam int OP_W    = 3;

  localparam logic [CLASS_W-1:0] CLS_MEM = 2'b00;
  localparam logic [CLASS_W-1:0] CLS_BEQ = 2'b01;

  localparam logic [OP_W-1:0] OP_AND = 3'b000;
  localparam logic [OP_W-1:0] OP_OR  = 3'b001;
  localparam logic [OP_W-1:0] OP_ADD = 3'b010;
  localparam logic [OP_W-1:0] OP_SUB = 3'b110;
  localparam logic [OP_W-1:0] OP_SLT = 3'b111;

  localparam logic [KEY_W-1:0] KEY_ADD = 4'b0000;
  localparam logic [KEY_W-1:0] KEY_SUB = 4'b0010;
  localparam logic [KEY_W-1:0] KEY_AND = 4'b0100;
  localparam logic [KEY_W-1:0] KEY_OR  = 4'b0101;
  localparam logic [KEY_W-1:0] KEY_SLT = 4'b1010;

  localparam int SUB_BIT = 2;

endpackage

// File: rtl/alu2_dec.sv
module alu2_dec
  import alu2_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class,
  input  logic [KEY_W-1:0]   key,
  output logic [OP_W-1:0]    alu_op
);

  logic [OP_W-1:0] key_op;

  always_comb begin
    case (key)
      KEY_ADD: key_op = OP_ADD;
      KEY_SUB: key_op = OP_SUB;
      KEY_AND: key_op = OP_AND;
      KEY_OR:  key_op = OP_OR;
      KEY_SLT: key_op = OP_SLT;
      default: key_op = OP_ADD;
    endcase
  end

  always_comb begin
    if (op_class[1])             alu_op = key_op;
    else if (op_class == CLS_BEQ) alu_op = OP_SUB;
    else                          alu_op = OP_ADD;
  end

endmodule

// File: rtl/alu2_addsub.sv
module alu2_addsub #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] b_eff
);

  localparam int NGRP = WIDTH / GROUP;

  assign b_eff = b ^ {WIDTH{sub}};

  for (genvar g = 0; g < NGRP; g++) begin : grp
    logic             cin;
    logic             cout;
    logic [GROUP-1:0] p;
    logic [GROUP-1:0] k;
    logic [GROUP:0]   c;

    if (g == 0) begin : g_first
      assign cin = sub;
    end else begin : g_next
      assign cin = grp[g-1].cout;
    end

    assign p = a[g*GROUP +: GROUP] ^ b_eff[g*GROUP +: GROUP];
    assign k = a[g*GROUP +: GROUP] & b_eff[g*GROUP +: GROUP];

    always_comb begin
      c[0] = cin;
      for (int i = 0; i < GROUP; i++) begin
        c[i+1] = k[i] | (p[i] & c[i]);
      end
    end

    assign sum[g*GROUP +: GROUP] = p ^ c[GROUP-1:0];
    // skip path: a fully propagating group passes its carry-in straight on
    assign cout = (&p) ? cin : c[GROUP];
  end

endmodule

// File: rtl/alu2_flags.sv
module alu2_flags
  import alu2_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [OP_W-1:0]  alu_op,
  input  logic             a_msb,
  input  logic             be_msb,
  input  logic             sum_msb,
  input  logic [WIDTH-1:0] result,
  output logic             less,
  output logic             overflow,
  output logic             zero
);

  logic sign_flip;
  logic arith;

  assign sign_flip = (a_msb == be_msb) && (sum_msb != a_msb);
  assign arith     = (alu_op == OP_ADD) || (alu_op == OP_SUB);
  assign less      = sum_msb ^ sign_flip;
  assign overflow  = arith & sign_flip;
  assign zero      = ~|result;

endmodule

// File: rtl/alu2_top.sv
module alu2_top
  import alu2_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [CLASS_W-1:0] op_class,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [OP_W-1:0]    alu_op,
  output logic [WIDTH-1:0]   result,
  output logic               zero,
  output logic               overflow
);

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] b_eff;
  logic             less;

  alu2_dec u_dec (
    .op_class (op_class),
    .key      (funct[KEY_W-1:0]),
    .alu_op   (alu_op)
  );

  alu2_addsub #(.WIDTH(WIDTH), .GROUP(GROUP)) u_addsub (
    .a     (a),
    .b     (b),
    .sub   (alu_op[SUB_BIT]),
    .sum   (sum),
    .b_eff (b_eff)
  );

  always_comb begin
    case (alu_op)
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, less};
      default: result = sum;
    endcase
  end

  alu2_flags #(.WIDTH(WIDTH)) u_flags (
    .alu_op   (alu_op),
    .a_msb    (a[WIDTH-1]),
    .be_msb   (b_eff[WIDTH-1]),
    .sum_msb  (sum[WIDTH-1]),
    .result   (result),
    .less     (less),
    .overflow (overflow),
    .zero     (zero)
  );

endmodule

// File: rtl/alu2_chk.sv
module alu2_chk
  import alu2_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [CLASS_W-1:0] op_class,
  input logic [FUNCT_W-1:0] funct,
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH-1:0]   b,
  input logic [OP_W-1:0]    alu_op,
  input logic [WIDTH-1:0]   result,
  input logic               zero,
  input logic               overflow
);

  logic known;
  assign known = !$isunknown({op_class, funct, a, b});

  always_comb begin
    if (known) begin
      // R1
      cls_mem_add_chk: assert (op_class != CLS_MEM || alu_op == OP_ADD);
      // R2
      cls_beq_sub_chk: assert (op_class != CLS_BEQ || alu_op == OP_SUB);
      // R7
      and_bitwise_chk: assert (alu_op != OP_AND || result == (a & b));
      // R8
      slt_upper_zero_chk: assert (alu_op != OP_SLT || result[WIDTH-1:1] == '0);
      // R9
      equal_sub_zero_chk: assert (!(alu_op == OP_SUB && a == b) || zero);
      // R10
      no_overflow_chk: assert (!overflow || alu_op == OP_ADD || alu_op == OP_SUB);
    end
  end

endmodule

bind alu2_top alu2_chk #(.WIDTH(WIDTH)) u_chk (
  .op_class (op_class),
  .funct    (funct),
  .a        (a),
  .b        (b),
  .alu_op   (alu_op),
  .result   (result),
  .zero     (zero),
  .overflow (overflow)
);

// File: tb/alu2_top_tb.sv
module alu2_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIDE       = 32;
  localparam int NARROW     = 8;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]      cls = '0;
  logic [5:0]      fn  = '0;
  logic [WIDE-1:0] a   = '0;
  logic [WIDE-1:0] b   = '0;

  logic [2:0]        w_op, n_op;
  logic [WIDE-1:0]   w_res;
  logic [NARROW-1:0] n_res;
  logic              w_z, w_v, n_z, n_v;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  alu2_top #(.WIDTH(WIDE), .GROUP(4)) u_dut (
    .op_class (cls), .funct (fn), .a (a), .b (b),
    .alu_op (w_op), .result (w_res), .zero (w_z), .overflow (w_v)
  );

  alu2_top #(.WIDTH(NARROW), .GROUP(2)) u_dut8 (
    .op_class (cls), .funct (fn), .a (a[NARROW-1:0]), .b (b[NARROW-1:0]),
    .alu_op (n_op), .result (n_res), .zero (n_z), .overflow (n_v)
  );

  function automatic logic [2:0] ref_op(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 3'b010;
    if (c == 2'b01) return 3'b110;
    case (f[3:0])
      4'b0000: return 3'b010;
      4'b0010: return 3'b110;
      4'b0100: return 3'b000;
      4'b0101: return 3'b001;
      4'b1010: return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return "R1";
    if (c == 2'b01) return "R2";
    if (!(f[3:0] inside {4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b1010})) return "R5";
    if (c == 2'b11) return "R4";
    return "R3";
  endfunction

  task automatic check_one(input int w, input string who, input logic [2:0] g_op,
                           input longint unsigned g_res, input bit g_z, input bit g_v);
    longint unsigned mask, ua, ub, e_res;
    longint sa, sb, exact, smax, smin;
    logic [2:0] e_op;
    bit e_z, e_v, bad;
    string rtag;
    mask  = (64'd1 << w) - 1;
    ua    = longint'(a) & mask;
    ub    = longint'(b) & mask;
    sa    = ua[w-1] ? longint'(ua) - (longint'(1) << w) : longint'(ua);
    sb    = ub[w-1] ? longint'(ub) - (longint'(1) << w) : longint'(ub);
    smax  = (longint'(1) << (w-1)) - 1;
    smin  = -(longint'(1) << (w-1));
    e_op  = ref_op(cls, fn);
    e_v   = 1'b0;
    exact = 0;
    case (e_op)
      3'b010: begin e_res = (ua + ub) & mask; exact = sa + sb; e_v = (exact > smax) || (exact < smin); rtag = "R6"; end
      3'b110: begin e_res = (ua - ub) & mask; exact = sa - sb; e_v = (exact > smax) || (exact < smin); rtag = "R6"; end
      3'b000: begin e_res = ua & ub; rtag = "R7"; end
      3'b001: begin e_res = ua | ub; rtag = "R7"; end
      default: begin e_res = (sa < sb) ? 1 : 0; rtag = "R8"; end
    endcase
    e_z = (e_res == 0);
    bad = 1'b0;
    n_cmp++;
    if (g_op !== e_op) begin
      bad = 1'b1;
      $display("FAIL %s %s op cls=%b fn=%b: got %b exp %b", op_tag(cls, fn), who, cls, fn, g_op, e_op);
    end
    if (g_res !== e_res) begin
      bad = 1'b1;
      $display("FAIL %s %s result a=%h b=%h: got %h exp %h", rtag, who, ua, ub, g_res, e_res);
    end
    if (g_z !== e_z) begin
      bad = 1'b1;
      $display("FAIL R9 %s zero: got %b exp %b", who, g_z, e_z);
    end
    if (g_v !== e_v) begin
      bad = 1'b1;
      $display("FAIL R10 %s overflow a=%h b=%h op=%b: got %b exp %b", who, ua, ub, e_op, g_v, e_v);
    end
    if (bad) n_bad++;
  endtask

  task automatic compare_both();
    check_one(WIDE, "wide", w_op, longint'(w_res), w_z, w_v);
    check_one(NARROW, "narrow", n_op, longint'(n_res), n_z, n_v);
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [WIDE-1:0] x, input logic [WIDE-1:0] y);
    @(posedge clk);
    cls = c; fn = f; a = x; b = y;
    @(negedge clk);
    compare_both();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog after %0d cycles: got running exp finished", cycles);
      finish_run();
    end
  end

  logic [WIDE-1:0] pa [8];
  logic [WIDE-1:0] pb [8];
  logic [5:0]      key6 [5];

  initial begin
    pa[0] = 32'h0000_0000; pb[0] = 32'h0000_0000;
    pa[1] = 32'h7FFF_FFFF; pb[1] = 32'h0000_0001;
    pa[2] = 32'h8000_0000; pb[2] = 32'h0000_0001;
    pa[3] = 32'h8000_0000; pb[3] = 32'hFFFF_FFFF;
    pa[4] = 32'h7FFF_FFFF; pb[4] = 32'hFFFF_FFFF;
    pa[5] = 32'h1234_5678; pb[5] = 32'h1234_5678;
    pa[6] = 32'hFFFF_FFFF; pb[6] = 32'h0000_0001;
    pa[7] = 32'hF0F0_F0F0; pb[7] = 32'h0FF0_0FF0;
    key6[0] = 6'b100000; key6[1] = 6'b100010; key6[2] = 6'b100100;
    key6[3] = 6'b100101; key6[4] = 6'b101010;

    // power-up state with all inputs at zero: add of zeros, zero flag set (R1, R9)
    @(negedge clk);
    compare_both();

    // every class against every function code over signed corner pairs (R1..R5, R6, R8, R10)
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 64; f++)
        for (int p = 0; p < 8; p++)
          apply(2'(c), 6'(f), pa[p], pb[p]);

    // directed: set-on-less-than where a-b overflows (R8), upper function bits ignored (R3)
    apply(2'b10, 6'b001010, 32'h8000_0000, 32'h0000_0001);
    apply(2'b10, 6'b111010, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(2'b11, 6'b010100, 32'hDEAD_BEEF, 32'h0F0F_0F0F);
    apply(2'b01, 6'b100101, 32'h0000_0042, 32'h0000_0042);

    // narrow copy: every first operand against spread second operands, all five ops (R6, R7, R8, R10)
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 16; y++)
        for (int k = 0; k < 5; k++)
          apply(2'b10, key6[k], {4{8'(x)}}, {4{8'(y * 17)}});

    // random mix across classes and operands
    for (int r = 0; r < 3000; r++)
      apply(2'($urandom), 6'($urandom), $urandom, $urandom);

    finish_run();
  end

endmodule